// File: doc/BRIEF.md
# Iterative Radix-2 Montgomery Modular Multiplier

This block computes the Montgomery product of two residues, S = A·B·2^(-K) mod N, for a K-bit odd modulus N. A request is accepted with a single-cycle `start` while `ready` is high. The operands and the modulus are captured in that cycle, and the caller may change them afterwards. The block first forms the sum B+N once. It then runs one iteration per bit of A, least significant bit first. Each iteration adds one of four candidate addends (zero, N, B, or B+N) to a running sum and halves the result.

The addend is chosen from the current bit of A and the quotient bit. The quotient bit is the parity of the running sum plus that addend. The running sum stays as a pair of redundant vectors (a sum vector and a carry vector) across all iterations, so no iteration contains a carry chain longer than one full adder. After the last iteration, one carry-propagate addition folds the pair into a binary value. A conditional subtraction of N then returns a fully reduced result. The block is meant to sit under a modular exponentiation sequencer that keeps its values in Montgomery form.

Top module: `montmul_r2`

## Requirements
- R1: After reset, `ready` is 1, `done` is 0 and `result` is 0.
- R2: For odd N and operands A, B < N, the `result` reported with `done` equals A·B·2^(-K) mod N and is strictly less than N.
- R3: If either operand is zero, the result is zero.
- R4: The result is correct at the extremes: A = B = N-1, the smallest modulus N = 3 and the largest modulus N = 2^K-1.
- R5: `done` rises at the (K+3)-th rising clock edge after the edge that accepts `start`.
- R6: `ready` is 0 from the edge that accepts `start` until the edge that raises `done`. `ready` is 1 while `done` is high, and `done` lasts exactly one cycle.
- R7: A `start` pulse while `ready` is 0 is ignored. The running operation completes with its own operands at its normal time, and no second operation follows.
- R8: `result` keeps its value, and `done` stays low, until an accepted `start` produces a new result. This holds while the operand inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted only while `ready` is 1 |
| opa | input | K | Operand A, below N |
| opb | input | K | Operand B, below N |
| modn | input | K | Modulus N, odd |
| ready | output | 1 | High when idle and able to accept `start` |
| done | output | 1 | One-cycle pulse marking a new `result` |
| result | output | K | Montgomery product, held between operations |

## Verification
The hardest case to reach from the ports is a raw sum that lands in [N, 2N), so that the final subtraction is needed. A second hard case is a carry vector whose upper bits fill the two guard bits. Both are most likely when the addend is B+N on most iterations. The bench therefore drives A = B = N-1 with the all-ones modulus, and a set of random moduli with the top bit forced. It also tries the smallest modulus. Ignoring a mid-operation request is checked by pulsing `start` with different operands part-way through an operation. The bench then confirms both the original result and the absence of a second `done`.

// File: rtl/mm_pkg.sv
package mm_pkg;

  // Controller phases
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PRE  = 3'd1,
    PH_ITER = 3'd2,
    PH_CONV = 3'd3,
    PH_RED  = 3'd4
  } mm_phase_e;

  // Addend choice encoded as {a_bit, q_bit}
  typedef enum logic [1:0] {
    ADD_ZERO = 2'b00,
    ADD_MOD  = 2'b01,
    ADD_B    = 2'b10,
    ADD_BN   = 2'b11
  } mm_addsel_e;

endpackage

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int K = 32
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  output logic      ready,
  output logic      load_fire,
  output logic      pre_fire,
  output logic      iter_fire,
  output logic      conv_fire,
  output logic      red_fire
);
  localparam int CW = (K > 1) ? $clog2(K) : 1;
  localparam logic [CW-1:0] LAST = CW'(K - 1);

  mm_phase_e       phase_q;
  logic [CW-1:0]   cnt_q;

  assign ready     = (phase_q == PH_IDLE);
  assign load_fire = ready && start;
  assign pre_fire  = (phase_q == PH_PRE);
  assign iter_fire = (phase_q == PH_ITER);
  assign conv_fire = (phase_q == PH_CONV);
  assign red_fire  = (phase_q == PH_RED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_PRE;
          cnt_q   <= '0;
        end
        PH_PRE:  phase_q <= PH_ITER;
        PH_ITER: begin
          if (cnt_q == LAST) phase_q <= PH_CONV;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        PH_CONV: phase_q <= PH_RED;
        PH_RED:  phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mm_addend_sel.sv
module mm_addend_sel
  import mm_pkg::*;
#(
  parameter int W = 34
) (
  input  logic         a_bit,
  input  logic         q_bit,
  input  logic [W-1:0] b_val,
  input  logic [W-1:0] n_val,
  input  logic [W-1:0] bn_val,
  output logic [W-1:0] addend
);
  mm_addsel_e sel;
  assign sel = mm_addsel_e'({a_bit, q_bit});

  always_comb begin
    case (sel)
      ADD_ZERO: addend = '0;
      ADD_MOD:  addend = n_val;
      ADD_B:    addend = b_val;
      ADD_BN:   addend = bn_val;
      default:  addend = '0;
    endcase
  end

endmodule

// File: rtl/mm_csa_row.sv
module mm_csa_row #(
  parameter int W = 34
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] psum,
  output logic [W-1:0] pcar
);
  // One full adder per column; carries move up one column
  assign pcar[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_col
    assign psum[i] = x[i] ^ y[i] ^ z[i];
    if (i > 0) begin : g_car
      assign pcar[i] = (x[i-1] & y[i-1]) | (x[i-1] & z[i-1]) | (y[i-1] & z[i-1]);
    end
  end

endmodule

// File: rtl/montmul_r2.sv
module montmul_r2
  import mm_pkg::*;
#(
  parameter int K = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [K-1:0] opa,
  input  logic [K-1:0] opb,
  input  logic [K-1:0] modn,
  output logic         ready,
  output logic         done,
  output logic [K-1:0] result
);
  localparam int W = K + 2;

  // Final reduction: raw value is below 2N
  function automatic logic [K-1:0] fold_reduce(input logic [W-1:0] raw, input logic [W-1:0] m);
    logic [W-1:0] t;
    t = (raw >= m) ? (raw - m) : raw;
    return t[K-1:0];
  endfunction

  // One halving step of the redundant pair
  function automatic logic [W-1:0] half_vec(input logic [W-1:0] v);
    return {1'b0, v[W-1:1]};
  endfunction

  logic load_fire, pre_fire, iter_fire, conv_fire, red_fire;

  logic [K-1:0] a_sh;
  logic [W-1:0] b_q, n_q, bn_q;
  logic [W-1:0] ss_q, sc_q, bin_q;
  logic [K-1:0] res_q;
  logic         done_q;

  logic         a_bit, q_bit;
  logic [W-1:0] addend, psum, pcar;
  logic         psum_lsb;

  mm_ctrl #(.K(K)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ready     (ready),
    .load_fire (load_fire),
    .pre_fire  (pre_fire),
    .iter_fire (iter_fire),
    .conv_fire (conv_fire),
    .red_fire  (red_fire)
  );

  assign a_bit = a_sh[0];
  assign q_bit = ss_q[0] ^ sc_q[0] ^ (a_bit & b_q[0]);

  mm_addend_sel #(.W(W)) u_sel (
    .a_bit  (a_bit),
    .q_bit  (q_bit),
    .b_val  (b_q),
    .n_val  (n_q),
    .bn_val (bn_q),
    .addend (addend)
  );

  mm_csa_row #(.W(W)) u_row (
    .x    (ss_q),
    .y    (sc_q),
    .z    (addend),
    .psum (psum),
    .pcar (pcar)
  );

  assign psum_lsb = psum[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sh   <= '0;
      b_q    <= '0;
      n_q    <= '0;
      bn_q   <= '0;
      ss_q   <= '0;
      sc_q   <= '0;
      bin_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= red_fire;
      if (load_fire) begin
        a_sh <= opa;
        b_q  <= {2'b00, opb};
        n_q  <= {2'b00, modn};
      end
      if (pre_fire) begin
        bn_q <= b_q + n_q;
        ss_q <= '0;
        sc_q <= '0;
      end
      if (iter_fire) begin
        ss_q <= half_vec(psum);
        sc_q <= half_vec(pcar);
        a_sh <= {1'b0, a_sh[K-1:1]};
      end
      if (conv_fire) bin_q <= ss_q + sc_q;
      if (red_fire)  res_q <= fold_reduce(bin_q, n_q);
    end
  end

  assign done   = done_q;
  assign result = res_q;

endmodule

// File: rtl/mm_chk.sv
module mm_chk #(
  parameter int K = 32,
  parameter int W = K + 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ready,
  input logic         done,
  input logic [K-1:0] result,
  input logic [W-1:0] n_q,
  input logic         red_fire,
  input logic         iter_fire,
  input logic         psum_lsb
);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  result_reduced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({2'b00, result} < n_q));

  // R2
  even_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iter_fire |-> !psum_lsb);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !red_fire |=> $stable(result));

  // R6
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iter_fire |-> !ready);

endmodule

bind montmul_r2 mm_chk #(.K(K)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ready     (ready),
  .done      (done),
  .result    (result),
  .n_q       (n_q),
  .red_fire  (red_fire),
  .iter_fire (iter_fire),
  .psum_lsb  (psum_lsb)
);

// File: tb/sim_montmul_r2.sv
`timescale 1ns/1ps
module sim_montmul_r2;
  localparam int KB = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [KB-1:0] opa = '0, opb = '0, modn = '0;
  logic          ready, done;
  logic [KB-1:0] result;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  montmul_r2 #(.K(KB)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .opa(opa), .opb(opb), .modn(modn),
    .ready(ready), .done(done), .result(result)
  );

  initial begin
    #(20.0 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Reference: reduce A*B mod N, then halve K times modulo N
  function automatic logic [KB-1:0] ref_mont(input logic [KB-1:0] a, input logic [KB-1:0] b,
                                             input logic [KB-1:0] n);
    logic [127:0] x;
    x = ({64'd0, a} * {64'd0, b}) % {96'd0, n};
    for (int i = 0; i < KB; i++) begin
      if (x[0]) x = (x + {96'd0, n}) >> 1;
      else      x = x >> 1;
    end
    return x[KB-1:0];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one operation; return result, latency in negedges, and ready-high count while busy
  task automatic run_op(input logic [KB-1:0] a, input logic [KB-1:0] b, input logic [KB-1:0] n,
                        output logic [KB-1:0] res, output int lat, output int rdy_busy);
    @(negedge clk);
    opa = a; opb = b; modn = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1; rdy_busy = 0;
    while (!done && lat < 1000) begin
      if (ready) rdy_busy++;
      @(negedge clk);
      lat++;
    end
    res = result;
  endtask

  task automatic one(input string req, input logic [KB-1:0] a, input logic [KB-1:0] b,
                     input logic [KB-1:0] n);
    logic [KB-1:0] r; int lat, rb;
    run_op(a, b, n, r, lat, rb);
    check(req, {32'd0, r}, {32'd0, ref_mont(a, b, n)});
  endtask

  task automatic t_reset();
    check("R1 ready", {63'd0, ready}, 64'd1);
    check("R1 done", {63'd0, done}, 64'd0);
    check("R1 result", {32'd0, result}, 64'd0);
  endtask

  task automatic t_zero();
    one("R3 a=0", 32'd0, 32'h1234_5677, 32'h9abc_def1);
    one("R3 b=0", 32'h0fed_cba9, 32'd0, 32'h9abc_def1);
    check("R3 zero value", {32'd0, result}, 64'd0);
  endtask

  task automatic t_edges();
    one("R4 max operands", 32'hffff_fffe, 32'hffff_fffe, 32'hffff_ffff);
    one("R4 n=3 a=b=2", 32'd2, 32'd2, 32'd3);
    one("R4 n=3 a=1 b=2", 32'd1, 32'd2, 32'd3);
    one("R4 a=b=n-1", 32'h8000_0002, 32'h8000_0002, 32'h8000_0003);
    one("R4 n=1", 32'd0, 32'd0, 32'd1);
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      logic [KB-1:0] n, a, b;
      n = $urandom() | 32'd1;
      if (i % 2 == 0) n[KB-1] = 1'b1;
      if (n < 32'd3) n = 32'd3;
      a = $urandom() % n;
      b = $urandom() % n;
      one("R2 random", a, b, n);
    end
  endtask

  task automatic t_timing();
    logic [KB-1:0] r; int lat, rb;
    run_op(32'h0000_1234, 32'h0000_5678, 32'hc000_0001, r, lat, rb);
    check("R5 latency", lat, KB + 4);
    check("R6 ready low while busy", rb, 0);
    check("R6 ready with done", {63'd0, ready}, 64'd1);
    @(negedge clk);
    check("R6 done one cycle", {63'd0, done}, 64'd0);
  endtask

  task automatic t_busy_ignore();
    logic [KB-1:0] n1, a1, b1, first;
    int lat, seen;
    n1 = 32'hd000_0035; a1 = 32'h1357_9bdf; b1 = 32'h2468_ace0;
    @(negedge clk);
    opa = a1; opb = b1; modn = n1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    repeat (5) begin @(negedge clk); lat++; end
    opa = 32'h0000_0003; opb = 32'h0000_0005; modn = 32'h0000_000b; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 1000) begin @(negedge clk); lat++; end
    first = result;
    check("R7 original operands kept", {32'd0, first}, {32'd0, ref_mont(a1, b1, n1)});
    check("R7 normal latency", lat, KB + 4);
    seen = 0;
    repeat (2 * KB + 8) begin @(negedge clk); if (done) seen++; end
    check("R7 no second operation", seen, 0);
    check("R7 result unchanged", {32'd0, result}, {32'd0, first});
  endtask

  task automatic t_hold();
    logic [KB-1:0] keep; int seen;
    one("R8 setup", 32'h0bad_cafe, 32'h0dea_dbee, 32'hf00d_0001);
    keep = result;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      opa = $urandom(); opb = $urandom(); modn = $urandom() | 32'd1;
      @(negedge clk);
      if (done) seen++;
    end
    check("R8 result held", {32'd0, result}, {32'd0, keep});
    check("R8 no done without start", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_zero();
    t_edges();
    t_timing();
    t_busy_ignore();
    t_hold();
    t_random();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule